// File: doc/BRIEF.md
# Adaptive Zero-Current Switch Timing Controller

This block produces the two gate-drive signals of a synchronous boost converter that runs in discontinuous conduction under pulse-frequency modulation. A one-clock start strobe marks each switching period, and the block measures the spacing between strobes. When a period starts, the low-side switch is driven for half of the last measured period. After one clock of dead time, the high-side (rectifier) switch is driven for one of eight on-time settings.

A short, programmable time after the rectifier turns off, the block samples a digitised switch-node level through a two-flop synchroniser. A high level means inductor current was still flowing, so the next on-time is made longer. A low level means the current had already reversed, so the next on-time is made shorter. In steady state the setting dithers between two neighbouring values that straddle zero current. An enable from the output-voltage comparator gates the start of new periods.

Top module: `zcs_gate_timer`

## Requirements
- R1: After reset both drives are low and stay low until the first enabled start strobe, and the trim index is 0, so the first rectifier pulse lasts HS_BASE clocks.
- R2: Every start strobe measures the number of clocks since the previous strobe. The low-side pulse that a strobe starts lasts that count halved and rounded down. The first strobe after reset uses INIT_HALF instead.
- R3: The two drives are never high together, and exactly one clock with both low separates the end of the low-side pulse from the start of the high-side pulse.
- R4: The high-side pulse lasts HS_BASE + HS_STEP*k clocks, where k is the 3-bit trim index (0 to 7).
- R5: A sampled switch-node level of 1 raises the trim index by one for the next period.
- R6: A sampled switch-node level of 0 lowers the trim index by one for the next period.
- R7: The trim index saturates at 7 when raised and at 0 when lowered. It never wraps.
- R8: Let the high-side drive turn off at edge e, and let d be smp_dly, with 0 treated as 1. The sample is the switch-node level registered at edge e+d-2, which the synchroniser delivers at edge e+d.
- R9: When the sampled level alternates period by period, the on-time alternates between two adjacent settings.
- R10: A strobe that arrives while run_en is low starts no period and leaves the trim index unchanged. A period already under way completes even if run_en falls, and switching resumes at the first strobe seen with run_en high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_start | input | 1 | One-clock strobe that opens a switching period |
| run_en | input | 1 | Output below reference; high allows new periods |
| sw_node | input | 1 | Digitised switch-node level (asynchronous) |
| smp_dly | input | DLY_W | Clocks from high-side turn-off to sample (1 to 15) |
| ls_gate | output | 1 | Low-side switch drive |
| hs_gate | output | 1 | High-side (rectifier) switch drive |

## Verification
The hardest point to reach is the exact sample instant. The bench must show that a switch-node transition one clock either side of the boundary flips the trim decision. To do this, the driver watches the high-side drive fall, counts negative edges from that moment, and toggles the switch-node input after exactly three clocks in one period and four in the next, with smp_dly set to 6. The opposite trim directions, seen as the following rectifier pulse widths, confirm the synchroniser latency and the placement of the sample. The saturation limits are reached by runs of identical samples that push the index past 7 and below 0.

// File: rtl/zcs_gate_timer.sv
module zcs_gate_timer #(
  parameter int PER_W     = 8,
  parameter int DLY_W     = 4,
  parameter int INIT_HALF = 16,
  parameter int HS_BASE   = 2,
  parameter int HS_STEP   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_start,
  input  logic             run_en,
  input  logic             sw_node,
  input  logic [DLY_W-1:0] smp_dly,
  output logic             ls_gate,
  output logic             hs_gate
);
  localparam int NSET  = 8;
  localparam int IDX_W = $clog2(NSET);

  typedef enum logic [2:0] {S_IDLE, S_LS, S_DEAD, S_HS, S_WAIT} st_t;

  st_t              st;
  logic [PER_W-1:0] cnt, per_cnt, half_now, half_ld, d_eff;
  logic             per_ok, sw_q1, sw_q2;
  logic [IDX_W-1:0] idx;
  logic [PER_W-1:0] on_tab [NSET];

  for (genvar g = 0; g < NSET; g++) begin : g_on
    assign on_tab[g] = PER_W'(HS_BASE + HS_STEP * g);
  end

  assign half_now = per_ok ? (per_cnt >> 1) : PER_W'(INIT_HALF);
  assign half_ld  = (half_now == '0) ? PER_W'(1) : half_now;
  assign d_eff    = (smp_dly == '0) ? PER_W'(1) : PER_W'(smp_dly);
  assign ls_gate  = (st == S_LS);
  assign hs_gate  = (st == S_HS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_cnt <= '0;
      per_ok  <= 1'b0;
    end else if (cyc_start) begin
      per_cnt <= PER_W'(1);
      per_ok  <= 1'b1;
    end else if (per_cnt != '1) begin
      per_cnt <= per_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_q1 <= 1'b0;
      sw_q2 <= 1'b0;
    end else begin
      sw_q1 <= sw_node;
      sw_q2 <= sw_q1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
      idx <= '0;
    end else begin
      case (st)
        S_IDLE: if (cyc_start && run_en) begin
          st  <= S_LS;
          cnt <= half_ld - 1'b1;
        end
        S_LS: if (cnt == '0) st <= S_DEAD;
              else cnt <= cnt - 1'b1;
        S_DEAD: begin
          st  <= S_HS;
          cnt <= on_tab[idx] - 1'b1;
        end
        S_HS: if (cnt == '0) begin
          st  <= S_WAIT;
          cnt <= d_eff - 1'b1;
        end else cnt <= cnt - 1'b1;
        S_WAIT: if (cnt == '0) begin
          st <= S_IDLE;
          if (sw_q2 && idx != IDX_W'(NSET - 1)) idx <= idx + 1'b1;
          else if (!sw_q2 && idx != '0)        idx <= idx - 1'b1;
        end else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(ls_gate && hs_gate)); // R3
  AST_DEAD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    ls_gate |=> !hs_gate); // R3
  AST_HS_AFTER_LS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_gate) |-> $past(ls_gate, 2)); // R3
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (idx != $past(idx)) |-> ((idx == $past(idx) + 1'b1) || (idx == $past(idx) - 1'b1))); // R5
  AST_IDX_SAT_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (idx == IDX_W'(NSET - 1)) |=> (idx != '0)); // R7
  AST_IDX_SAT_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (idx == '0) |=> (idx != IDX_W'(NSET - 1))); // R7
  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !run_en) |=> !ls_gate); // R10
endmodule

// File: tb/zcs_gate_timer_tb_top.sv
module zcs_gate_timer_tb_top;
  localparam int INIT_HALF = 16;
  localparam int HS_BASE   = 2;
  localparam int HS_STEP   = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cyc_start = 1'b0;
  logic       run_en = 1'b1;
  logic       sw_node = 1'b0;
  logic [3:0] smp_dly = 4'd4;
  logic       ls_gate, hs_gate;

  always #4 clk = ~clk;

  zcs_gate_timer #(.INIT_HALF(INIT_HALF), .HS_BASE(HS_BASE), .HS_STEP(HS_STEP)) dut_i (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .run_en(run_en),
    .sw_node(sw_node), .smp_dly(smp_dly), .ls_gate(ls_gate), .hs_gate(hs_gate));

  typedef struct { int ls; int hs; string tag; } item_t;
  item_t exp_q[$];

  int  n_chk = 0, n_fail = 0;
  int  m_idx = 0, prev_gap = 0;
  bit  first = 1'b1, done = 1'b0;

  task automatic check(bit ok, string tag, string what, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  task automatic run_cycle(int gap, bit sw, int flip_at, bit drop_en, string tag);
    item_t it;
    bit    smp, hs_prev;
    int    after;
    if (run_en) begin
      it.ls  = first ? INIT_HALF : prev_gap / 2;
      it.hs  = HS_BASE + HS_STEP * m_idx;
      it.tag = tag;
      exp_q.push_back(it);
      smp = (flip_at >= 0 && flip_at <= int'(smp_dly) - 3) ? ~sw : sw;
      if (smp && m_idx < 7) m_idx++;
      else if (!smp && m_idx > 0) m_idx--;
    end
    first = 1'b0;
    prev_gap = gap;
    after = -1;
    hs_prev = 1'b0;
    for (int k = 0; k < gap; k++) begin
      @(negedge clk);
      if (k == 0) begin
        cyc_start = 1'b1;
        sw_node = sw;
      end else cyc_start = 1'b0;
      if (drop_en && k == 3) run_en = 1'b0;
      if (after >= 0) after++;
      if (hs_prev && !hs_gate) after = 0;
      hs_prev = hs_gate;
      if (flip_at >= 0 && after == flip_at) sw_node = ~sw;
    end
  endtask

  int ls_cnt = 0, hs_cnt = 0, gap_cnt = 0;
  bit ls_prev = 1'b0, hs_prv = 1'b0, in_gap = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (ls_gate && hs_gate) check(1'b0, "R3", "drives overlap", 1, 0);
      if (ls_gate) ls_cnt++;
      if (hs_gate) hs_cnt++;
      if (ls_prev && !ls_gate) begin in_gap = 1'b1; gap_cnt = 0; end
      if (in_gap && !ls_gate && !hs_gate) gap_cnt++;
      if (hs_gate) in_gap = 1'b0;
      if (hs_prv && !hs_gate) begin
        if (exp_q.size() == 0) check(1'b0, "R10", "unexpected pulse", 1, 0);
        else begin
          item_t e;
          e = exp_q.pop_front();
          check(ls_cnt == e.ls, "R2", "low-side width", ls_cnt, e.ls);
          check(gap_cnt == 1, "R3", "dead time", gap_cnt, 1);
          check(hs_cnt == e.hs, e.tag, "high-side width", hs_cnt, e.hs);
        end
        ls_cnt = 0; hs_cnt = 0;
      end
      ls_prev = ls_gate;
      hs_prv = hs_gate;
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "R1", "watchdog expired", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(!ls_gate && !hs_gate, "R1", "drives idle after reset", int'({ls_gate, hs_gate}), 0);
    end
    run_cycle(80, 1'b0, -1, 1'b0, "R1");
    run_cycle(80, 1'b0, -1, 1'b0, "R7");
    for (int i = 0; i < 9; i++) run_cycle(80, 1'b1, -1, 1'b0, (i < 8) ? "R5" : "R7");
    run_cycle(80, 1'b1, -1, 1'b0, "R7");
    for (int i = 0; i < 6; i++) run_cycle(80, i[0], -1, 1'b0, "R9");
    for (int i = 0; i < 3; i++) run_cycle(80, 1'b0, -1, 1'b0, "R6");
    run_cycle(100, 1'b1, -1, 1'b0, "R4");
    run_cycle(100, 1'b1, -1, 1'b0, "R4");
    run_cycle(91, 1'b0, -1, 1'b0, "R4");
    run_cycle(91, 1'b1, -1, 1'b0, "R4");
    run_cycle(91, 1'b1, -1, 1'b0, "R4");
    smp_dly = 4'd6;
    run_cycle(90, 1'b1, 3, 1'b0, "R8");
    run_cycle(90, 1'b1, 4, 1'b0, "R8");
    run_cycle(90, 1'b1, 3, 1'b0, "R8");
    run_cycle(90, 1'b0, -1, 1'b0, "R8");
    smp_dly = 4'd4;
    run_cycle(90, 1'b1, -1, 1'b1, "R10");
    run_cycle(90, 1'b1, -1, 1'b0, "R10");
    run_cycle(90, 1'b1, -1, 1'b0, "R10");
    run_en = 1'b1;
    run_cycle(90, 1'b0, -1, 1'b0, "R10");
    run_cycle(90, 1'b0, -1, 1'b0, "R10");
    repeat (100) @(negedge clk);
    check(exp_q.size() == 0, "R10", "pulses missing", exp_q.size(), 0);
    check(!ls_gate && !hs_gate, "R10", "idle at end", int'({ls_gate, hs_gate}), 0);
    finish_run();
  end
endmodule